// File: doc/BRIEF.md
# Bus Access Stretch Controller

This block holds the one-byte configuration that shapes bus timing and applies it to every access the CPU starts. Each access address is classified against a relocatable 512-byte internal register block: it falls inside that block, in the 512-byte window directly above it, or anywhere else in external space. The controller then picks a stretch count from the configuration, holds its ready output low for that many E-clock periods, and reports the region together with whether the access should travel over an 8-bit data path.

The configuration register is readable at all times. Its reset contents depend on the operating mode sampled during reset. In normal operation software gets exactly one write after each reset. In special operation every write lands. The base address of the register block is an input, so the window above it moves with it.

Top module: `bus_stretch_ctl`

## Requirements
- R1: `cfg_rdata` always shows the stored configuration with bit 7 reading 0. The bits are: bit 6 narrow-path enable for the window, bits 5:4 window stretch, bits 3:2 external stretch, bit 1 ROM remap, bit 0 ROM enable. A write stores `cfg_wdata[6:0]` in bits 6:0 and is visible from the next cycle.
- R2: With `mode_special`=0, only the first `cfg_wr` after reset is stored and later writes are ignored. Only reset clears this lock, so changing `mode_sel` does not re-arm it. Any write, in either mode, sets the lock.
- R3: With `mode_special`=1, every `cfg_wr` is stored.
- R4: Synchronous reset loads 0x0F when `mode_sel`=00 (single-chip). It loads 0x0C for 01 (expanded wide), 10 (expanded narrow) and 11 (peripheral).
- R5: The offset is (`acc_addr` − `reg_base`) mod 2^16. An offset below 512 is the register block (region code 00). An offset from 512 to 1023 is the window (01). Any other offset is external (10).
- R6: The stretch count is 0 for the register block. It comes from bits 5:4 for the window and from bits 3:2 for external space, with the 2-bit value giving the number of E clocks directly. The count is 0 in single-chip and peripheral modes. The configuration in use is the one read out in the cycle of the start.
- R7: An accepted access with stretch 0 leaves `acc_ready` high.
- R8: `acc_start` is accepted only while `acc_ready`=1. With stretch N>0, `acc_ready` falls in the cycle after the start. It rises again at the clock edge that samples the Nth `eclk_tick` pulse after the start.
- R9: A start request while `acc_ready`=0 is ignored and changes neither the timing nor the latched outputs.
- R10: In expanded wide mode (01), `acc_narrow` is 1 for a window access with bit 6 set. In expanded narrow mode (10), it is 1 for window and external accesses whatever bit 6 holds. In every other case it is 0.
- R11: `acc_region` and `acc_narrow` are captured at an accepted start and valid from the next cycle. They hold until the next accepted start, and reset clears them to 00 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_special | input | 1 | 1 = special operation (unrestricted writes) |
| mode_sel | input | 2 | 00 single-chip, 01 expanded wide, 10 expanded narrow, 11 peripheral |
| reg_base | input | ADDR_W | Base address of the 512-byte register block |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data (bits 6:0) |
| cfg_rdata | output | 8 | Configuration read data |
| eclk_tick | input | 1 | One-cycle pulse per E-clock period |
| acc_start | input | 1 | Access start request |
| acc_addr | input | ADDR_W | Access address |
| acc_ready | output | 1 | High when no stretch is pending |
| acc_region | output | 2 | Region of the last accepted access |
| acc_narrow | output | 1 | Last accepted access uses an 8-bit path |

## Verification
The bench builds the block with the default 16-bit address and a 512-byte block span. With these values, wrap-around of the offset at 0xFFFF can be reached, as can the exact edges at offsets 511/512 and 1023/1024 and a register block placed near the top of the address map. The 2-bit stretch fields let every count from 0 to 3 occur in both stretched regions, under sparse and dense E-clock pulses and with start requests made during a stretch.

// File: rtl/bsc_pkg.sv
// Shared types for the bus access stretch controller.
// Assumes a 2-bit stretch field, as fixed by the configuration byte layout.
package bsc_pkg;
    localparam int STR_W = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_WIDE   = 2'b01,
        MODE_NARROW = 2'b10,
        MODE_PERIPH = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        RGN_REGS   = 2'b00,
        RGN_FOLLOW = 2'b01,
        RGN_EXT    = 2'b10
    } region_e;
endpackage

// File: rtl/bsc_cfg_reg.sv
// Configuration byte with write-once protection in normal operation.
// Assumes mode_sel is steady around reset; the reset value follows it.
module bsc_cfg_reg (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_special,
    input  bsc_pkg::bus_mode_e  mode,
    input  logic                cfg_wr,
    input  logic [6:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata
);
    import bsc_pkg::*;

    localparam logic [6:0] RST_SINGLE = 7'h0F;
    localparam logic [6:0] RST_OTHER  = 7'h0C;

    logic [6:0] cfg_q;
    logic       locked_q;

    // Store configuration; lock after the first write, reset re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= (mode == MODE_SINGLE) ? RST_SINGLE : RST_OTHER;
            locked_q <= 1'b0;
        end else if (cfg_wr) begin
            if (mode_special || !locked_q) begin
                cfg_q <= cfg_wdata;
            end
            locked_q <= 1'b1;
        end
    end

    assign cfg_rdata = {1'b0, cfg_q};

    assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !mode_special && locked_q) |=> $stable(cfg_rdata));

    assert_special_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && mode_special) |=> (cfg_rdata == {1'b0, $past(cfg_wdata)}));
endmodule

// File: rtl/bsc_region_decode.sv
// Classifies an address against the relocatable register block and the
// window above it, and selects stretch count and data path width.
// Assumes 2*BLOCK_SPAN fits in the address width.
module bsc_region_decode #(
    parameter int ADDR_W     = 16,
    parameter int BLOCK_SPAN = 512
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-1:0]          base,
    input  bsc_pkg::bus_mode_e         mode,
    input  logic                       narrow_en,
    input  logic [bsc_pkg::STR_W-1:0]  follow_str,
    input  logic [bsc_pkg::STR_W-1:0]  ext_str,
    output bsc_pkg::region_e           region,
    output logic [bsc_pkg::STR_W-1:0]  stretch,
    output logic                       narrow
);
    import bsc_pkg::*;

    localparam logic [ADDR_W-1:0] SPAN_END   = ADDR_W'(BLOCK_SPAN);
    localparam logic [ADDR_W-1:0] FOLLOW_END = ADDR_W'(2 * BLOCK_SPAN);

    logic [ADDR_W-1:0] offset;
    logic              ext_bus;

    // Offset from the block base, wrapping modulo the address space.
    always_comb begin
        offset = addr - base;
    end

    // Region selection from the offset.
    always_comb begin
        if (offset < SPAN_END)        region = RGN_REGS;
        else if (offset < FOLLOW_END) region = RGN_FOLLOW;
        else                          region = RGN_EXT;
    end

    // Stretch count; only expanded modes use an external bus.
    always_comb begin
        ext_bus = (mode == MODE_WIDE) || (mode == MODE_NARROW);
        stretch = '0;
        if (ext_bus) begin
            case (region)
                RGN_FOLLOW: stretch = follow_str;
                RGN_EXT:    stretch = ext_str;
                default:    stretch = '0;
            endcase
        end
    end

    // Data path width for the access.
    always_comb begin
        narrow = 1'b0;
        if (mode == MODE_WIDE) begin
            narrow = (region == RGN_FOLLOW) && narrow_en;
        end else if (mode == MODE_NARROW) begin
            narrow = (region != RGN_REGS);
        end
    end
endmodule

// File: rtl/bsc_stretch_timer.sv
// Holds ready low for a loaded number of E-clock pulses and captures the
// access attributes at each accepted start.
// Assumes eclk_tick is a single-cycle pulse per E-clock period.
module bsc_stretch_timer #(
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eclk_tick,
    input  logic              acc_start,
    input  logic [CNT_W-1:0]  stretch_in,
    input  bsc_pkg::region_e  region_in,
    input  logic              narrow_in,
    output logic              acc_ready,
    output bsc_pkg::region_e  region_q,
    output logic              narrow_q
);
    import bsc_pkg::*;

    logic [CNT_W-1:0] remain_q;

    // Count down pending stretch; accept a start only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            region_q <= RGN_REGS;
            narrow_q <= 1'b0;
        end else if (remain_q != '0) begin
            if (eclk_tick) begin
                remain_q <= remain_q - 1'b1;
            end
        end else if (acc_start) begin
            remain_q <= stretch_in;
            region_q <= region_in;
            narrow_q <= narrow_in;
        end
    end

    assign acc_ready = (remain_q == '0);

    assert_zero_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && acc_start && stretch_in == '0) |=> acc_ready);

    assert_stretch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && acc_start && stretch_in != '0) |=> !acc_ready);

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ready && !eclk_tick) |=> !acc_ready);

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ready && acc_start) |=> ($stable(region_q) && $stable(narrow_q)));
endmodule

// File: rtl/bus_stretch_ctl.sv
// Top level: configuration register, address decode and stretch timer.
// Assumes one access in flight at a time, gated by acc_ready.
module bus_stretch_ctl #(
    parameter int ADDR_W     = 16,
    parameter int BLOCK_SPAN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_special,
    input  logic [1:0]        mode_sel,
    input  logic [ADDR_W-1:0] reg_base,
    input  logic              cfg_wr,
    input  logic [6:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              eclk_tick,
    input  logic              acc_start,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_ready,
    output logic [1:0]        acc_region,
    output logic              acc_narrow
);
    import bsc_pkg::*;

    bus_mode_e              mode;
    region_e                dec_region;
    region_e                lat_region;
    logic [STR_W-1:0]       dec_stretch;
    logic                   dec_narrow;

    assign mode = bus_mode_e'(mode_sel);

    bsc_cfg_reg i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_special (mode_special),
        .mode         (mode),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata)
    );

    bsc_region_decode #(
        .ADDR_W     (ADDR_W),
        .BLOCK_SPAN (BLOCK_SPAN)
    ) i_dec (
        .addr       (acc_addr),
        .base       (reg_base),
        .mode       (mode),
        .narrow_en  (cfg_rdata[6]),
        .follow_str (cfg_rdata[5:4]),
        .ext_str    (cfg_rdata[3:2]),
        .region     (dec_region),
        .stretch    (dec_stretch),
        .narrow     (dec_narrow)
    );

    bsc_stretch_timer #(
        .CNT_W (STR_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .eclk_tick  (eclk_tick),
        .acc_start  (acc_start),
        .stretch_in (dec_stretch),
        .region_in  (dec_region),
        .narrow_in  (dec_narrow),
        .acc_ready  (acc_ready),
        .region_q   (lat_region),
        .narrow_q   (acc_narrow)
    );

    assign acc_region = lat_region;

    assert_no_stretch_internal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SINGLE || mode == MODE_PERIPH || dec_region == RGN_REGS)
        |-> (dec_stretch == '0));

    assert_regs_never_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && acc_start && dec_region == RGN_REGS) |=> !acc_narrow);
endmodule

// File: tb/test_bus_stretch_ctl.sv
module test_bus_stretch_ctl;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_special = 1'b0;
    logic [1:0]        mode_sel = 2'b00;
    logic [ADDR_W-1:0] reg_base = '0;
    logic              cfg_wr = 1'b0;
    logic [6:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              eclk_tick = 1'b0;
    logic              acc_start = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_ready;
    logic [1:0]        acc_region;
    logic              acc_narrow;

    int n_vec = 0;
    int n_bad = 0;
    bit armed = 0;

    always #10 clk = ~clk;

    bus_stretch_ctl i_bus_stretch_ctl (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .mode_sel(mode_sel),
        .reg_base(reg_base), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eclk_tick(eclk_tick), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_ready(acc_ready), .acc_region(acc_region), .acc_narrow(acc_narrow)
    );

    // Behavioural reference model
    logic [7:0] m_cfg;
    int m_used, m_rem, m_region, m_narrow, off, rgn, n, nar;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = (mode_sel == 2'b00) ? 8'h0F : 8'h0C;   // R4
            m_used = 0; m_rem = 0; m_region = 0; m_narrow = 0;
            armed = 1;
        end else begin
            if (m_rem > 0) begin
                if (eclk_tick) m_rem = m_rem - 1;          // R8
            end else if (acc_start) begin
                off = (int'(acc_addr) - int'(reg_base)) & 'hFFFF;  // R5
                rgn = (off < 512) ? 0 : ((off < 1024) ? 1 : 2);
                n = 0;                                      // R6
                if (mode_sel == 2'b01 || mode_sel == 2'b10) begin
                    if (rgn == 1) n = (m_cfg >> 4) & 3;
                    else if (rgn == 2) n = (m_cfg >> 2) & 3;
                end
                nar = 0;                                    // R10
                if (mode_sel == 2'b01 && rgn == 1 && m_cfg[6]) nar = 1;
                if (mode_sel == 2'b10 && rgn != 0) nar = 1;
                m_rem = n; m_region = rgn; m_narrow = nar;  // R11
            end
            if (cfg_wr) begin                               // R2 R3
                if (mode_special || m_used == 0) m_cfg = {1'b0, cfg_wdata};
                m_used = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            chk(cfg_rdata === m_cfg, "R1 R2 R3 cfg_rdata", int'(cfg_rdata), int'(m_cfg));
            chk(acc_ready === (m_rem == 0), "R7 R8 R9 acc_ready", int'(acc_ready), int'(m_rem == 0));
            chk(acc_region === 2'(m_region), "R5 R11 acc_region", int'(acc_region), m_region);
            chk(acc_narrow === 1'(m_narrow), "R10 acc_narrow", int'(acc_narrow), m_narrow);
        end
    end

    task automatic do_reset(input logic [1:0] m, input logic sp);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; mode_special = sp;
        cfg_wr = 1'b0; acc_start = 1'b0; eclk_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 reset value, R8 idle ready
        chk(cfg_rdata === ((m == 2'b00) ? 8'h0F : 8'h0C), "R4 reset value",
            int'(cfg_rdata), (m == 2'b00) ? 'h0F : 'h0C);
        chk(acc_ready === 1'b1, "R8 ready after reset", int'(acc_ready), 1);
    endtask

    task automatic write_cfg(input logic [6:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pick_addr();
        int o;
        case ($urandom % 8)
            0: o = 0;
            1: o = 511;
            2: o = 512;
            3: o = 1023;
            4: o = 1024;
            5: o = 'hFFFF;
            6: o = $urandom % 'h10000;
            default: o = 512 + ($urandom % 512);
        endcase
        acc_addr = reg_base + 16'(o);
    endtask

    task automatic run_random(input int cycles, input bit writes, input int tick_mod);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            eclk_tick = (($urandom % tick_mod) == 0);
            acc_start = acc_ready ? (($urandom % 2) == 0) : (($urandom % 4) == 0); // R9
            pick_addr();
            cfg_wr = writes && (($urandom % 12) == 0);
            cfg_wdata = 7'($urandom);
            if (($urandom % 200) == 0) reg_base = 16'($urandom);
        end
        @(negedge clk);
        cfg_wr = 1'b0; acc_start = 1'b0;
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            reg_base = (m == 3) ? 16'hFF00 : 16'(m * 16'h1200);
            do_reset(2'(m), 1'b0);
            write_cfg(7'h75);              // R2 first write stored
            write_cfg(7'h2A);              // R2 second ignored
            mode_sel = 2'(m ^ 1);          // R2 mode change does not re-arm
            write_cfg(7'h11);
            mode_sel = 2'(m);
            run_random(400, 1'b1, 3);
            do_reset(2'(m), 1'b1);         // R3 special writes
            run_random(2500, 1'b1, 2);
            run_random(1500, 1'b1, 5);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule